// File: doc/BRIEF.md
# Decimating ADC Capture Buffer

This block takes a 32-line parallel ADC bus, running on the converter's own clock, and turns it into a stored record of samples. The 32 lines carry four 8-bit sample sets. On the board, some lines may have their differential pair swapped and the lines may not arrive in bit order. Two build-time parameters correct this: a per-line polarity mask and a line-to-bit map. The corrected 32-bit word is registered. One word out of every `DECIM` converter clocks is written into a dual-port block RAM. Writing stops by itself once all `DEPTH` locations hold data.

The second RAM port sits behind a Wishbone slave in a separate bus clock domain, so the host can read the record. The same slave holds a one-bit run register. Clearing the bit freezes capture. Setting it again starts a fresh record at address zero. A status word shows the number of stored words and a full flag, both carried safely into the bus clock domain. Whether the four sets form one interleaved channel or two channels of two sets each is decided by the host when it reads the words. The buffer stores all four sets of a kept sample side by side in every layout.

Top module: `adc_capture_buffer`

## Requirements
- R1: Stored bit i of a word equals input line SRC(i) XOR POL_MASK[SRC(i)], where SRC(i) is the 5-bit field i of `LANE_MAP` (bits 5i+4..5i). Sample set k therefore sits in word bits 8k+7..8k, with set 0 in bits 7:0.
- R2: While capturing, exactly one corrected sample per `DECIM` ADC clock cycles is written. Consecutive stored words come from input samples exactly `DECIM` cycles apart.
- R3: A record is written at ascending addresses starting from 0. The stored-word count rises by one with each write.
- R4: After `DEPTH` writes the full flag is set, the count equals `DEPTH`, and no further write happens until a restart.
- R5: A bus read with address bit `AW` equal to 0 returns the RAM word at address bits `AW-1:0`. Every request gets a one-cycle acknowledge on the bus clock edge after it is presented.
- R6: The run bit is bit 0 of the word at bus address {1, 0…0}. It resets to 1 and reads back as written. While it is 0, no write happens, and count and full stay frozen.
- R7: Writing 1 to the run bit while it is 0 clears the count and the full flag and starts a new record. Writing 1 while it is already 1 has no effect.
- R8: The status word at bus address {1, 0…01} holds the full flag in bit 31 and the stored-word count in bits `AW:0`. Both are synchronized into the bus clock domain, and all other bits read 0.
- R9: Bus writes to the RAM region (address bit `AW` equal to 0) change neither the RAM contents nor the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | ADC sample clock |
| adc_rst | input | 1 | Synchronous active-high reset, ADC domain |
| adc_lines | input | 32 | Raw ADC data lines, as routed on the board |
| wb_clk | input | 1 | Bus clock |
| wb_rst | input | 1 | Synchronous active-high reset, bus domain |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | AW+1 | Word address; bit AW selects registers |
| wb_dat_w | input | 32 | Bus write data |
| wb_dat_r | output | 32 | Bus read data |
| wb_ack | output | 1 | Bus acknowledge |

## Verification
The assertions check, on every ADC clock, the write-side invariants. A write advances the count by exactly one. No write happens while full or while stopped. Two writes are never back to back when decimating. The count never exceeds `DEPTH`, full implies a count of `DEPTH`, and a restart clears the record state on the next cycle. On the bus side, every cycle they check that acknowledges are single pulses and that writes to the RAM window leave the run bit alone. Only the bench scenarios can show that the lane map and polarity mask recover the intended value and that stored words are exactly `DECIM` input samples apart. The same holds for the crossings between the two clock domains: restart, freeze and stable readback.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int LINES = 32;
  localparam int SET_W = 8;
  localparam int SETS  = LINES / SET_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int MAP_W = LINES * IDX_W;

  // Line-to-bit map in which bit i is fed by line i.
  function automatic logic [MAP_W-1:0] straight_map();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < LINES; i++) begin
      m[i*IDX_W +: IDX_W] = IDX_W'(i);
    end
    return m;
  endfunction

endpackage

// File: rtl/adc_cap_sync.sv
module adc_cap_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/adc_lane_fixup.sv
module adc_lane_fixup
  import adc_cap_pkg::*;
#(
  parameter logic [LINES-1:0] POL_MASK = '0,
  parameter logic [MAP_W-1:0] LANE_MAP = straight_map()
) (
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] fixed
);

  for (genvar g = 0; g < LINES; g++) begin : g_bit
    localparam int SRC = int'(LANE_MAP[g*IDX_W +: IDX_W]);
    assign fixed[g] = raw[SRC] ^ POL_MASK[SRC];
  end

endmodule

// File: rtl/adc_cap_ram.sv
module adc_cap_ram #(
  parameter int AW = 10,
  parameter int DW = 32,
  localparam int WORDS = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_cap_writer.sv
module adc_cap_writer #(
  parameter int DEPTH = 1024,
  parameter int DECIM = 100,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample,
  input  logic          run_async,
  input  logic          tog_async,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [AW:0]   cnt_gray,
  output logic          full
);

  localparam int            CW       = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] DEC_LAST = CW'(DECIM - 1);
  localparam logic [AW:0]   CNT_LAST = (AW+1)'(DEPTH - 1);
  localparam logic [AW:0]   CNT_MAX  = (AW+1)'(DEPTH);

  logic          run_s, tog_s, run_d, tog_d;
  logic          restart;
  logic [CW-1:0] dec_q;
  logic [DW-1:0] samp_q;
  logic          take_q;
  logic [AW:0]   cnt_q;
  logic          full_q;
  logic [AW:0]   gray_q;

  adc_cap_sync #(.W(2), .RST_VAL(2'b00)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   ({run_async, tog_async}),
    .q   ({run_s, tog_s})
  );

  assign restart = tog_s ^ tog_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d  <= 1'b0;
      tog_d  <= 1'b0;
      dec_q  <= '0;
      samp_q <= '0;
      take_q <= 1'b0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      gray_q <= '0;
    end else begin
      run_d  <= run_s;
      tog_d  <= tog_s;
      samp_q <= sample;
      if (restart || dec_q == DEC_LAST) dec_q <= '0;
      else                              dec_q <= dec_q + 1'b1;
      take_q <= (dec_q == '0) && run_s && !full_q && !restart;
      if (restart) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else if (we) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) full_q <= 1'b1;
      end
      gray_q <= cnt_q ^ (cnt_q >> 1);
    end
  end

  assign we       = take_q && !full_q && !restart;
  assign waddr    = cnt_q[AW-1:0];
  assign wdata    = samp_q;
  assign cnt_gray = gray_q;
  assign full     = full_q;

  a_r4_full_no_write: assert property (@(posedge clk) disable iff (rst)
    full_q |-> !we);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

  a_r4_full_means_depth: assert property (@(posedge clk) disable iff (rst)
    full_q |-> cnt_q == CNT_MAX);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    we |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0) && !full_q);

  a_r6_stopped_no_write: assert property (@(posedge clk) disable iff (rst)
    (!run_s && !run_d) |-> !we);

  if (DECIM > 1) begin : g_gap
    a_r2_write_gap: assert property (@(posedge clk) disable iff (rst)
      we |=> !we);
  end

endmodule

// File: rtl/adc_cap_wb.sv
module adc_cap_wb #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [AW:0]   adr,
  input  logic [31:0]   dat_w,
  output logic [31:0]   dat_r,
  output logic          ack,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [31:0]   ram_rdata,
  output logic          run,
  output logic          tog,
  input  logic [AW:0]   cnt_gray_async,
  input  logic          full_async
);

  logic          req;
  logic          reg_sel;
  logic          full_s;
  logic [AW:0]   gray_s;
  logic [AW:0]   cnt_bin;
  logic [31:0]   status;
  logic          ram_sel_q;
  logic [31:0]   reg_q;

  adc_cap_sync #(.W(AW+2), .RST_VAL('0)) u_stat_sync (
    .clk (clk),
    .rst (rst),
    .d   ({full_async, cnt_gray_async}),
    .q   ({full_s, gray_s})
  );

  always_comb begin
    cnt_bin[AW] = gray_s[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      cnt_bin[i] = cnt_bin[i+1] ^ gray_s[i];
    end
  end

  always_comb begin
    status         = '0;
    status[31]     = full_s;
    status[AW:0]   = cnt_bin;
  end

  assign req       = cyc && stb && !ack;
  assign reg_sel   = adr[AW];
  assign ram_re    = req && !reg_sel;
  assign ram_raddr = adr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack       <= 1'b0;
      run       <= 1'b1;
      tog       <= 1'b0;
      ram_sel_q <= 1'b0;
      reg_q     <= '0;
    end else begin
      ack <= req;
      if (req) begin
        ram_sel_q <= !reg_sel;
        reg_q     <= adr[0] ? status : {31'b0, run};
        if (we && reg_sel && !adr[0]) begin
          run <= dat_w[0];
          if (dat_w[0] && !run) tog <= !tog;
        end
      end
    end
  end

  assign dat_r = ram_sel_q ? ram_rdata : reg_q;

  a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r9_ram_write_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (req && we && !reg_sel) |=> run == $past(run));

endmodule

// File: rtl/adc_capture_buffer.sv
module adc_capture_buffer
  import adc_cap_pkg::*;
#(
  parameter int               DEPTH    = 1024,
  parameter int               DECIM    = 100,
  parameter logic [LINES-1:0] POL_MASK = '0,
  parameter logic [MAP_W-1:0] LANE_MAP = straight_map(),
  localparam int              AW       = $clog2(DEPTH)
) (
  input  logic             adc_clk,
  input  logic             adc_rst,
  input  logic [LINES-1:0] adc_lines,
  input  logic             wb_clk,
  input  logic             wb_rst,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic [AW:0]      wb_adr,
  input  logic [31:0]      wb_dat_w,
  output logic [31:0]      wb_dat_r,
  output logic             wb_ack
);

  logic [LINES-1:0] fixed;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [LINES-1:0] wdata;
  logic [AW:0]      cnt_gray;
  logic             full;
  logic             run;
  logic             tog;
  logic             ram_re;
  logic [AW-1:0]    ram_raddr;
  logic [31:0]      ram_rdata;

  adc_lane_fixup #(.POL_MASK(POL_MASK), .LANE_MAP(LANE_MAP)) u_fix (
    .raw   (adc_lines),
    .fixed (fixed)
  );

  adc_cap_writer #(.DEPTH(DEPTH), .DECIM(DECIM), .DW(LINES)) u_wr (
    .clk       (adc_clk),
    .rst       (adc_rst),
    .sample    (fixed),
    .run_async (run),
    .tog_async (tog),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .cnt_gray  (cnt_gray),
    .full      (full)
  );

  adc_cap_ram #(.AW(AW), .DW(LINES)) u_ram (
    .wclk  (adc_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .rclk  (wb_clk),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  adc_cap_wb #(.AW(AW)) u_bus (
    .clk            (wb_clk),
    .rst            (wb_rst),
    .cyc            (wb_cyc),
    .stb            (wb_stb),
    .we             (wb_we),
    .adr            (wb_adr),
    .dat_w          (wb_dat_w),
    .dat_r          (wb_dat_r),
    .ack            (wb_ack),
    .ram_re         (ram_re),
    .ram_raddr      (ram_raddr),
    .ram_rdata      (ram_rdata),
    .run            (run),
    .tog            (tog),
    .cnt_gray_async (cnt_gray),
    .full_async     (full)
  );

endmodule

// File: tb/sim_adc_capture_buffer.sv
module sim_adc_capture_buffer;

  localparam int          DEPTH = 16;
  localparam int          DECIM = 5;
  localparam int          AW    = 4;
  localparam logic [31:0] INV   = 32'hA5C3_0F96;
  localparam logic [AW:0] A_CTRL = 5'b10000;
  localparam logic [AW:0] A_STAT = 5'b10001;

  function automatic int src_of(int i);
    return (i * 5 + 3) % 32;
  endfunction

  function automatic logic [159:0] mk_map();
    logic [159:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) m[i*5 +: 5] = 5'(src_of(i));
    return m;
  endfunction

  localparam logic [159:0] TB_MAP = mk_map();

  // Physical line levels that must decode to logical value v (R1).
  function automatic logic [31:0] encode(logic [31:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[src_of(i)] = v[i] ^ INV[src_of(i)];
    return r;
  endfunction

  logic        aclk = 1'b0;
  logic        wclk = 1'b0;
  logic        arst = 1'b1;
  logic        wrst = 1'b1;
  logic [31:0] adc_lines;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [AW:0] wb_adr = '0;
  logic [31:0] wb_dat_w = '0;
  logic [31:0] wb_dat_r;
  logic        wb_ack;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          chk_q[$];

  always #10 aclk = ~aclk;
  initial begin
    #3;
    forever #10 wclk = ~wclk;
  end

  adc_capture_buffer #(
    .DEPTH(DEPTH), .DECIM(DECIM), .POL_MASK(INV), .LANE_MAP(TB_MAP)
  ) u0 (
    .adc_clk(aclk), .adc_rst(arst), .adc_lines(adc_lines),
    .wb_clk(wclk), .wb_rst(wrst), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
    .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
  );

  // ADC stream: logical value counts ADC cycles.
  initial begin
    logic [31:0] v;
    v = 32'h0000_1000;
    adc_lines = encode(v);
    forever begin
      @(negedge aclk);
      v = v + 1;
      adc_lines = encode(v);
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one scoreboard entry per read acknowledge.
  initial begin
    forever begin
      @(negedge wclk);
      if (wb_ack && exp_q.size() > 0) begin
        logic [31:0] e;
        string       t;
        bit          c;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        c = chk_q.pop_front();
        if (c) check(wb_dat_r === e, t, wb_dat_r, e);
      end
    end
  end

  task automatic bus_read(input logic [AW:0] a, input bit chk, input logic [31:0] e,
                          input string t, output logic [31:0] d, output int lat);
    @(negedge wclk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    chk_q.push_back(chk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = a;
    lat = 0;
    do begin
      @(negedge wclk);
      lat++;
    end while (!wb_ack && lat < 20);
    d = wb_dat_r;
    wb_cyc = 1'b0; wb_stb = 1'b0;
  endtask

  task automatic bus_write(input logic [AW:0] a, input logic [31:0] d);
    int n;
    @(negedge wclk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = a; wb_dat_w = d;
    n = 0;
    do begin
      @(negedge wclk);
      n++;
    end while (!wb_ack && n < 20);
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
  endtask

  task automatic wait_full(output logic [31:0] s);
    int lat;
    for (int k = 0; k < 400; k++) begin
      bus_read(A_STAT, 1'b0, '0, "poll", s, lat);
      if (s[31]) break;
      repeat (5) @(negedge wclk);
    end
  endtask

  task automatic check_record(output logic [31:0] first, output logic [31:0] last);
    logic [31:0] d;
    int          lat;
    bus_read(5'd0, 1'b0, '0, "w0", first, lat);
    for (int j = 1; j < DEPTH; j++) begin
      bus_read(5'(j), 1'b1, first + 32'(j * DECIM), "R1 R2 R3 word spacing", d, lat);
      last = d;
    end
  endtask

  logic [31:0] s, s1, s2, w0, wl, w0b, wlb, d, keep3;
  int          lat;

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge aclk);
    arst = 1'b0;
    wrst = 1'b0;
    @(negedge wclk);
    check(wb_ack === 1'b0, "R5 ack idle after reset", {31'b0, wb_ack}, 32'h0);

    // R6: run bit resets to 1, one-cycle ack (R5)
    bus_read(A_CTRL, 1'b1, 32'h1, "R6 run reset value", d, lat);
    check(lat == 1, "R5 ack latency", 32'(lat), 32'h1);

    // R4 / R8: first record fills
    wait_full(s);
    check(s == 32'h8000_0010, "R4 R8 full status", s, 32'h8000_0010);
    check_record(w0, wl);

    // R7: writing 1 while running does nothing
    bus_write(A_CTRL, 32'h1);
    repeat (40) @(negedge wclk);
    bus_read(A_STAT, 1'b1, 32'h8000_0010, "R7 write 1 while running", d, lat);

    // R9: RAM window writes ignored
    bus_read(5'd3, 1'b0, '0, "pre", keep3, lat);
    bus_write(5'd3, 32'hDEAD_BEEF);
    bus_read(5'd3, 1'b1, keep3, "R9 ram write ignored", d, lat);
    bus_read(A_CTRL, 1'b1, 32'h1, "R9 run unchanged", d, lat);

    // R6: stop after full
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, 1'b1, 32'h0, "R6 run reads back 0", d, lat);
    repeat (60) @(negedge wclk);
    bus_read(A_STAT, 1'b1, 32'h8000_0010, "R6 stopped status frozen", d, lat);

    // R7: restart clears and records again
    bus_write(A_CTRL, 32'h1);
    repeat (20) @(negedge wclk);
    bus_read(A_STAT, 1'b0, '0, "st", s, lat);
    check(!s[31] && s[AW:0] < 5'(DEPTH), "R7 restart clears count and full", s, 32'h0);
    wait_full(s);
    check(s == 32'h8000_0010, "R4 R8 refill status", s, 32'h8000_0010);
    check_record(w0b, wlb);
    check(w0b > wl, "R7 new record is newer", w0b, wl + 1);

    // R6: stop mid-record, count frozen below depth
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CTRL, 32'h1);
    repeat (40) @(negedge wclk);
    bus_write(A_CTRL, 32'h0);
    repeat (20) @(negedge wclk);
    bus_read(A_STAT, 1'b0, '0, "s1", s1, lat);
    repeat (100) @(negedge wclk);
    bus_read(A_STAT, 1'b1, s1, "R6 frozen mid record", s2, lat);
    check(!s1[31] && s1[AW:0] > 0 && s1[AW:0] < 5'(DEPTH), "R6 R8 partial count",
          s1, 32'h0000_0008);

    repeat (5) @(negedge wclk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule